// File: doc/BRIEF.md
# Banked Address Extender with Common Window

This block widens a 16-bit processor address into a physical memory address. A small bank register, loaded by the processor through one decoded I/O port, supplies the upper physical address bits. The processor address passes through unchanged as the lower bits, so each bank looks like a full 64 KB space.

The top 16 KB of the processor space is a common window. Accesses there bypass translation and always reach one dedicated physical area placed above all banks, whatever bank is selected. This is where bank-switching code and interrupt handlers live.

A decoder turns the current mapping into chip selects: one per bank, plus one for the common area. Only an explicit port write changes the bank. An address that wraps from 0xFFFF to 0x0000 leaves it alone.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset the bank register holds 0.
- R2: When `io_wr` is high and `cpu_addr[7:0]` equals 0xFF, the clock edge loads `wr_data[1:0]` into the bank register. The new bank is used from the cycle after that edge.
- R3: The following leave the bank register unchanged: I/O writes to any other low address byte, memory accesses to any address (including 0x00FF), and idle cycles. Bits `wr_data[7:2]` are ignored.
- R4: For a processor address below 0xC000, `phys_addr` (19 bits) is {1'b0, bank[1:0], cpu_addr[15:0]}.
- R5: For a processor address in 0xC000–0xFFFF, `phys_addr` is 0x40000 + (cpu_addr − 0xC000), that is {1'b1, 4'b0000, cpu_addr[13:0]}, for every bank value.
- R6: While `mem_req` is high exactly one select is active. For a banked address it is `bank_cs[bank]` (bit index equals bank number). For a common address it is `common_cs`.
- R7: While `mem_req` is low, `bank_cs` is 0 and `common_cs` is 0.
- R8: The bank register keeps its value when the processor address wraps from 0xFFFF to 0x0000.
- R9: During the cycle in which a port write is presented, memory accesses still map through the old bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address; the low byte is the I/O port number |
| wr_data | input | 8 | Processor write data |
| mem_req | input | 1 | Memory access strobe |
| io_wr | input | 1 | I/O write strobe |
| phys_addr | output | 19 | Translated physical address |
| bank_cs | output | 4 | Per-bank chip selects, one-hot |
| common_cs | output | 1 | Chip select of the common area |

## Verification
On every cycle, the embedded properties check three things: the select outputs are one-hot under a memory strobe and all low without one; the bank register moves only on a decoded port write and then takes the written low bits; and the common-window address never depends on the bank. The bench scenarios show the rest. These are the concrete physical addresses for chosen banks, the window boundary at 0xBFFF/0xC000, the reset value, writes to a neighbouring port, and memory accesses to 0x00FF. They also cover an address wrap that must not move the bank, and the one-cycle lag between a port write and its effect.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    localparam int unsigned CPU_AW_DEF    = 16;
    localparam int unsigned BANK_W_DEF    = 2;
    localparam int unsigned DATA_W_DEF    = 8;
    localparam int unsigned IO_AW_DEF     = 8;
    localparam int unsigned COMMON_AW_DEF = 14;

    typedef enum logic {
        REGION_BANKED = 1'b0,
        REGION_COMMON = 1'b1
    } region_e;

endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg #(
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned IO_AW     = 8,
    parameter logic [IO_AW-1:0] PORT_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BANK_W-1:0] bank_q
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } state_t;

    state_t state_d, state_q;
    logic   port_hit;
    logic   unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:BANK_W];

    always_comb begin
        port_hit = io_wr && (io_addr == PORT_ADDR);
        state_d  = state_q;
        if (port_hit) begin
            state_d.bank = wr_data[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank_q = state_q.bank;

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == PORT_ADDR) |=> (bank_q == $past(wr_data[BANK_W-1:0]))); // R2
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == PORT_ADDR) |=> $stable(bank_q)); // R3

endmodule

// File: rtl/addr_translate.sv
module addr_translate
    import bank_map_pkg::*;
#(
    parameter int unsigned CPU_AW    = 16,
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned COMMON_AW = 14,
    localparam int unsigned PHYS_AW  = CPU_AW + BANK_W + 1,
    localparam int unsigned TAG_W    = CPU_AW - COMMON_AW
) (
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [BANK_W-1:0]  bank,
    output region_e            region,
    output logic [PHYS_AW-1:0] phys_addr
);

    logic [TAG_W-1:0] tag;

    always_comb begin
        tag = cpu_addr[CPU_AW-1:COMMON_AW];
        if (&tag) begin
            region    = REGION_COMMON;
            phys_addr = {1'b1, {(BANK_W + TAG_W){1'b0}}, cpu_addr[COMMON_AW-1:0]};
        end else begin
            region    = REGION_BANKED;
            phys_addr = {1'b0, bank, cpu_addr};
        end
    end

    AST_COMMON_LOW_HALF: assert final (region != REGION_COMMON
        || phys_addr[CPU_AW+BANK_W-1:COMMON_AW] == '0); // R5

endmodule

// File: rtl/chip_select_decode.sv
module chip_select_decode
    import bank_map_pkg::*;
#(
    parameter int unsigned BANK_W    = 2,
    localparam int unsigned NUM_BANKS = 1 << BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mem_req,
    input  region_e              region,
    input  logic [BANK_W-1:0]    bank,
    output logic [NUM_BANKS-1:0] bank_cs,
    output logic                 common_cs
);

    logic banked_req;

    assign banked_req = mem_req && (region == REGION_BANKED);
    assign common_cs  = mem_req && (region == REGION_COMMON);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign bank_cs[b] = banked_req && (bank == BANK_W'(b));
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones({bank_cs, common_cs}) == 1)); // R6
    AST_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> ($countones({bank_cs, common_cs}) == 0)); // R7

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
    import bank_map_pkg::*;
#(
    parameter int unsigned CPU_AW    = CPU_AW_DEF,
    parameter int unsigned BANK_W    = BANK_W_DEF,
    parameter int unsigned DATA_W    = DATA_W_DEF,
    parameter int unsigned IO_AW     = IO_AW_DEF,
    parameter int unsigned COMMON_AW = COMMON_AW_DEF,
    parameter logic [IO_AW-1:0] PORT_ADDR = '1,
    localparam int unsigned PHYS_AW   = CPU_AW + BANK_W + 1,
    localparam int unsigned NUM_BANKS = 1 << BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 mem_req,
    input  logic                 io_wr,
    output logic [PHYS_AW-1:0]   phys_addr,
    output logic [NUM_BANKS-1:0] bank_cs,
    output logic                 common_cs
);

    logic [BANK_W-1:0] bank_q;
    region_e           region;

    bank_select_reg #(
        .BANK_W    (BANK_W),
        .DATA_W    (DATA_W),
        .IO_AW     (IO_AW),
        .PORT_ADDR (PORT_ADDR)
    ) i_bank_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_addr (cpu_addr[IO_AW-1:0]),
        .wr_data (wr_data),
        .bank_q  (bank_q)
    );

    addr_translate #(
        .CPU_AW    (CPU_AW),
        .BANK_W    (BANK_W),
        .COMMON_AW (COMMON_AW)
    ) i_xlate (
        .cpu_addr  (cpu_addr),
        .bank      (bank_q),
        .region    (region),
        .phys_addr (phys_addr)
    );

    chip_select_decode #(
        .BANK_W (BANK_W)
    ) i_cs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_req   (mem_req),
        .region    (region),
        .bank      (bank_q),
        .bank_cs   (bank_cs),
        .common_cs (common_cs)
    );

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !common_cs) |-> (phys_addr[CPU_AW-1:0] == cpu_addr)); // R4
    AST_CS_MATCHES_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !common_cs) |-> bank_cs[phys_addr[CPU_AW+BANK_W-1:CPU_AW]]); // R6
    AST_COMMON_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        common_cs |-> (phys_addr[PHYS_AW-1] && phys_addr[CPU_AW+BANK_W-1:CPU_AW] == '0)); // R5

endmodule

// File: tb/test_bank_window_mapper.sv
module test_bank_window_mapper;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        mem_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [18:0] phys_addr;
    logic [3:0]  bank_cs;
    logic        common_cs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_window_mapper i_bank_window_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_data(wr_data),
        .mem_req(mem_req), .io_wr(io_wr), .phys_addr(phys_addr),
        .bank_cs(bank_cs), .common_cs(common_cs)
    );

    function automatic logic [18:0] exp_phys(input logic [15:0] a, input logic [1:0] b);
        if (a >= 16'hC000) return 19'h40000 + 19'(a - 16'hC000);
        return {1'b0, b, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Memory access presented after a falling edge, sampled away from the rising edge.
    task automatic mem_access(input string req, input logic [15:0] a, input logic [1:0] b);
        @(negedge clk);
        cpu_addr = a; mem_req = 1'b1; io_wr = 1'b0;
        #1;
        check({req, " phys"}, 32'(phys_addr), 32'(exp_phys(a, b)));
        if (a >= 16'hC000) begin
            check({req, " common_cs"}, 32'(common_cs), 32'd1);
            check({req, " bank_cs"}, 32'(bank_cs), 32'd0);
        end else begin
            check({req, " common_cs"}, 32'(common_cs), 32'd0);
            check({req, " bank_cs"}, 32'(bank_cs), 32'(4'b0001 << b));
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; wr_data = d; io_wr = 1'b1; mem_req = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic t_reset;
        mem_access("R1", 16'h1234, 2'd0);
    endtask

    task automatic t_bank_write;
        io_write(16'h00FF, 8'h02);
        mem_access("R2", 16'h1234, 2'd2);
        io_write(16'h00FF, 8'hFF);           // upper data bits dropped
        mem_access("R3 upper data", 16'h8001, 2'd3);
    endtask

    task automatic t_ignored;
        io_write(16'h00FE, 8'h01);
        mem_access("R3 other port", 16'h4000, 2'd3);
        mem_access("R3 mem at 0x00FF", 16'h00FF, 2'd3);
        @(negedge clk);
        mem_req = 1'b0; io_wr = 1'b0; wr_data = 8'h00;
        @(negedge clk);
        mem_access("R3 idle", 16'h0010, 2'd3);
    endtask

    task automatic t_common;
        mem_access("R5 base", 16'hC000, 2'd3);
        mem_access("R5 top", 16'hFFFF, 2'd3);
        io_write(16'h00FF, 8'h01);
        mem_access("R5 other bank", 16'hFFFF, 2'd1);
        mem_access("R4 boundary", 16'hBFFF, 2'd1);
        mem_access("R6 bank1", 16'h0000, 2'd1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        mem_req = 1'b0; cpu_addr = 16'h2000;
        #1;
        check("R7 bank_cs", 32'(bank_cs), 32'd0);
        check("R7 common_cs", 32'(common_cs), 32'd0);
        cpu_addr = 16'hD000;
        #1;
        check("R7 common idle", 32'(common_cs), 32'd0);
    endtask

    task automatic t_wrap;
        io_write(16'h00FF, 8'h02);
        mem_access("R8 before wrap", 16'hFFFE, 2'd2);
        mem_access("R8 at top", 16'hFFFF, 2'd2);
        mem_access("R8 after wrap", 16'h0000, 2'd2);
        mem_access("R8 next", 16'h0001, 2'd2);
    endtask

    task automatic t_same_cycle;
        // Bank is 2; present a port write of 0 and observe before the edge.
        @(negedge clk);
        cpu_addr = 16'h00FF; wr_data = 8'h00; io_wr = 1'b1; mem_req = 1'b1;
        #1;
        check("R9 old bank phys", 32'(phys_addr), 32'h200FF);
        check("R9 old bank cs", 32'(bank_cs), 32'b0100);
        @(negedge clk);
        io_wr = 1'b0;
        #1;
        check("R9 new bank phys", 32'(phys_addr), 32'h000FF);
        check("R2 new bank cs", 32'(bank_cs), 32'b0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank_write();
        t_ignored();
        t_common();
        t_idle();
        t_wrap();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule